// File: doc/BRIEF.md
# Fault Auto-Restart Timer

This block sits next to the on/off regulation logic of a cycle-skipping switch controller. The feedback enable line is pulled low by the secondary side whenever the output is above its target. When the output is shorted or the loop is open, the line is never pulled low. The block counts oscillator cycles in which the line stays high. If that run lasts a full fault window, the block withdraws its switching permit for an off period and then lets switching try again. This pattern repeats for as long as the fault lasts.

A line under-voltage flag stretches the off period: the off-period count is frozen while the flag is set, so switching cannot resume on a collapsing input. The same flag also holds off the first switching cycle after reset. A second input reports whether the line-sense function is fitted. When it is not, the under-voltage flag is ignored entirely. All timing is counted in strobes from the switching oscillator, one strobe per oscillator cycle. The block is clocked by a faster system clock.

Top module: `fault_restart_timer`

## Requirements
- R1: In the clock after a synchronous active-low reset, `off_enter` and `off_exit` are low, the cycle count is zero, and the block is in its enabled window. `sw_permit` is high there unless the under-voltage gate of R8 applies.
- R2: A strobe that samples `en_line` low (0 means pulled low, regulation met) while in the enabled window clears the fault count. While the line is pulled low at least once in every `ON_SPAN` strobes, `sw_permit` stays high.
- R3: When `ON_SPAN` consecutive strobes sample `en_line` high in the enabled window, `sw_permit` falls in the clock of the `ON_SPAN`-th strobe.
- R4: The off period lasts exactly `OFF_SPAN` strobes when no under-voltage gating applies. `sw_permit` returns high in the clock of the last of them. A fresh enabled window then starts, so a lasting fault alternates windows and off periods.
- R5: During an off period, a strobe seen with `line_uv`=1 and `sense_present`=1 does not advance the off count. The remaining off time resumes once the flag clears.
- R6: With `sense_present`=0, `line_uv` has no effect on the permit or on any timing.
- R7: `off_enter` is a one-clock pulse in the clock in which the permit is withdrawn. `off_exit` is a one-clock pulse in the clock in which it is restored.
- R8: After reset, with `line_uv`=1 and `sense_present`=1, `sw_permit` is low and the fault window does not count. `sw_permit` rises as soon as the flag clears.
- R9: Once a permitted strobe has occurred after reset, `line_uv` no longer withdraws the permit inside an enabled window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_tick | input | 1 | One-clock strobe at the start of each oscillator cycle |
| en_line | input | 1 | Feedback enable level, 0 = pulled low (output in regulation) |
| line_uv | input | 1 | Line under-voltage flag |
| sense_present | input | 1 | 1 when the line-sense function is fitted |
| sw_permit | output | 1 | Switching allowed for the current cycle |
| off_enter | output | 1 | One-clock pulse on entry to the off period |
| off_exit | output | 1 | One-clock pulse on leaving the off period |

## Verification
The assertions check several properties on every clock:
- both marker pulses last one clock and line up with the permit edges;
- the permit is never high during an off period;
- a pulled-low strobe zeroes the count;
- the count moves only on strobes;
- an under-voltage strobe in the off period leaves the count unchanged.

Only the bench scenarios can show the exact window and off-period lengths in strobes, the stretch followed by the correct remaining off time, and power-up holding. The same applies to the complete disregard of the flag when sensing is absent and to the flag's lack of effect once switching has started.

// File: rtl/ar_pkg.sv
// Package: shared types and helpers for the fault auto-restart timer.
// Assumes spans are at least 2 strobes long.
package ar_pkg;

    typedef enum logic {
        AR_RUN = 1'b0,
        AR_OFF = 1'b1
    } ar_state_e;

    // Larger of two spans, used to size the shared counter.
    function automatic int span_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ar_uv_qualify.sv
// Module: ar_uv_qualify
// Combines the line under-voltage flag with the sense-fitted flag.
// Assumes both inputs are already synchronous logic levels.
module ar_uv_qualify (
    input  logic line_uv,
    input  logic sense_present,
    output logic uv_eff
);

    // Under-voltage only counts when line sensing is fitted.
    always_comb begin
        uv_eff = line_uv & sense_present;
    end

endmodule

// File: rtl/ar_span_counter.sv
// Module: ar_span_counter
// Shared strobe counter used both for the fault window and the off period.
// Assumes clr and inc are never both required; clr wins if they are.
module ar_span_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    // Count register: clear, increment or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ar_sequencer.sv
// Module: ar_sequencer
// Enabled-window / off-period state machine with power-up gating.
// Assumes cyc_tick is a single-clock strobe and cnt comes from ar_span_counter.
module ar_sequencer
    import ar_pkg::*;
#(
    parameter int ON_SPAN  = 4160,
    parameter int OFF_SPAN = 16640,
    parameter int CNT_W    = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_tick,
    input  logic             en_line,
    input  logic             uv_eff,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output ar_state_e        state,
    output logic             permit,
    output logic             enter_p,
    output logic             exit_p
);

    localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(ON_SPAN - 1);
    localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_SPAN - 1);

    ar_state_e state_nxt;
    logic      launched;
    logic      go_off;
    logic      go_on;

    // Permit: enabled window, and either already launched or line healthy.
    always_comb begin
        permit = (state == AR_RUN) && (launched || !uv_eff);
    end

    // Next-state and counter command decode, evaluated on strobes only.
    always_comb begin
        state_nxt = state;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        go_off    = 1'b0;
        go_on     = 1'b0;
        if (cyc_tick) begin
            case (state)
                AR_RUN: begin
                    if (!permit) begin
                        cnt_inc = 1'b0;
                    end else if (!en_line) begin
                        cnt_clr = 1'b1;
                    end else if (cnt == WIN_LAST) begin
                        cnt_clr   = 1'b1;
                        state_nxt = AR_OFF;
                        go_off    = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                AR_OFF: begin
                    if (uv_eff) begin
                        cnt_inc = 1'b0;
                    end else if (cnt == OFF_LAST) begin
                        cnt_clr   = 1'b1;
                        state_nxt = AR_RUN;
                        go_on     = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                default: begin
                    state_nxt = AR_RUN;
                    cnt_clr   = 1'b1;
                end
            endcase
        end
    end

    // State register and transition markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= AR_RUN;
            enter_p <= 1'b0;
            exit_p  <= 1'b0;
        end else begin
            state   <= state_nxt;
            enter_p <= go_off;
            exit_p  <= go_on;
        end
    end

    // Launch flag: set by the first permitted strobe after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            launched <= 1'b0;
        end else if ((cyc_tick && permit) || go_on) begin
            launched <= 1'b1;
        end
    end

endmodule

// File: rtl/fault_restart_timer.sv
// Module: fault_restart_timer (top)
// Detects lost regulation on the feedback enable line and enforces an
// off period before switching retries. Spans are counted in oscillator strobes.
// Assumes all inputs are synchronous to clk.
module fault_restart_timer
    import ar_pkg::*;
#(
    parameter int ON_SPAN  = 4160,
    parameter int OFF_SPAN = 16640
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_tick,
    input  logic en_line,
    input  logic line_uv,
    input  logic sense_present,
    output logic sw_permit,
    output logic off_enter,
    output logic off_exit
);

    localparam int MAX_SPAN = span_max(ON_SPAN, OFF_SPAN);
    localparam int CNT_W    = $clog2(MAX_SPAN);

    logic             uv_eff;
    logic             cnt_clr;
    logic             cnt_inc;
    logic [CNT_W-1:0] cnt_q;
    ar_state_e        state_q;

    ar_uv_qualify i_uv (
        .line_uv       (line_uv),
        .sense_present (sense_present),
        .uv_eff        (uv_eff)
    );

    ar_span_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt_q)
    );

    ar_sequencer #(
        .ON_SPAN  (ON_SPAN),
        .OFF_SPAN (OFF_SPAN),
        .CNT_W    (CNT_W)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_tick (cyc_tick),
        .en_line  (en_line),
        .uv_eff   (uv_eff),
        .cnt      (cnt_q),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .state    (state_q),
        .permit   (sw_permit),
        .enter_p  (off_enter),
        .exit_p   (off_exit)
    );

endmodule

// File: rtl/fault_restart_timer_chk.sv
// Module: fault_restart_timer_chk
// Property checker bound into fault_restart_timer; observes ports and the
// shared count and state.
module fault_restart_timer_chk
    import ar_pkg::*;
#(
    parameter int ON_SPAN  = 4160,
    parameter int OFF_SPAN = 16640,
    parameter int CNT_W    = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_tick,
    input logic             en_line,
    input logic             line_uv,
    input logic             sense_present,
    input logic             sw_permit,
    input logic             off_enter,
    input logic             off_exit,
    input logic [CNT_W-1:0] cnt,
    input ar_state_e        state
);

    localparam int MAX_SPAN = span_max(ON_SPAN, OFF_SPAN);

    // R7
    enter_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_enter |=> !off_enter);

    // R7
    exit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_exit |=> !off_exit);

    // R3
    enter_drops_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_enter |-> !sw_permit);

    // R4
    exit_raises_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_exit |-> sw_permit);

    // R4
    off_no_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == AR_OFF) |-> !sw_permit);

    // R2
    low_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == AR_RUN && cyc_tick && !en_line && sw_permit) |=> (cnt == '0));

    // R5
    uv_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == AR_OFF && cyc_tick && line_uv && sense_present)
        |=> ($stable(cnt) && state == AR_OFF));

    // R2
    strobe_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_tick |=> $stable(cnt));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < MAX_SPAN);

endmodule

bind fault_restart_timer fault_restart_timer_chk #(
    .ON_SPAN  (ON_SPAN),
    .OFF_SPAN (OFF_SPAN),
    .CNT_W    (CNT_W)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cyc_tick      (cyc_tick),
    .en_line       (en_line),
    .line_uv       (line_uv),
    .sense_present (sense_present),
    .sw_permit     (sw_permit),
    .off_enter     (off_enter),
    .off_exit      (off_exit),
    .cnt           (cnt_q),
    .state         (state_q)
);

// File: tb/test_fault_restart_timer.sv
// Directed bench for fault_restart_timer with short spans.
module test_fault_restart_timer;

    localparam int CLK_PERIOD = 10;
    localparam int ON_SP      = 6;
    localparam int OFF_SP     = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_tick = 1'b0;
    logic en_line = 1'b1;
    logic line_uv = 1'b0;
    logic sense_present = 1'b1;
    logic sw_permit, off_enter, off_exit;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_restart_timer #(.ON_SPAN(ON_SP), .OFF_SPAN(OFF_SP)) i_fault_restart_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .cyc_tick      (cyc_tick),
        .en_line       (en_line),
        .line_uv       (line_uv),
        .sense_present (sense_present),
        .sw_permit     (sw_permit),
        .off_enter     (off_enter),
        .off_exit      (off_exit)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // One oscillator strobe; returns just after the clock that sampled it.
    task automatic one_tick();
        repeat (2) @(negedge clk);
        cyc_tick = 1'b1;
        @(negedge clk);
        cyc_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) one_tick();
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cyc_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        en_line = 1'b1; line_uv = 1'b0; sense_present = 1'b1;
        apply_reset();
        chk("R1 permit after reset", sw_permit, 1'b1);
        chk("R1 enter after reset", off_enter, 1'b0);
        chk("R1 exit after reset", off_exit, 1'b0);
    endtask

    task automatic t_regulate();
        en_line = 1'b1; line_uv = 1'b0; sense_present = 1'b1;
        apply_reset();
        for (int i = 0; i < 4 * ON_SP; i++) begin
            en_line = (i % 3 != 2);
            one_tick();
            chk("R2 permit held while regulated", sw_permit, 1'b1);
        end
        en_line = 1'b1;
        ticks(ON_SP - 1);
        chk("R2 window restarts after last low", sw_permit, 1'b1);
        one_tick();
        chk("R3 permit drops at window end", sw_permit, 1'b0);
    endtask

    task automatic t_fault();
        en_line = 1'b1; line_uv = 1'b0; sense_present = 1'b1;
        apply_reset();
        ticks(ON_SP - 1);
        chk("R3 permit before window end", sw_permit, 1'b1);
        one_tick();
        chk("R3 permit dropped", sw_permit, 1'b0);
        chk("R7 enter pulse", off_enter, 1'b1);
        chk("R7 no exit at entry", off_exit, 1'b0);
        @(negedge clk);
        chk("R7 enter pulse one clock", off_enter, 1'b0);
        ticks(OFF_SP - 1);
        chk("R4 still off", sw_permit, 1'b0);
        one_tick();
        chk("R4 permit restored", sw_permit, 1'b1);
        chk("R7 exit pulse", off_exit, 1'b1);
        @(negedge clk);
        chk("R7 exit pulse one clock", off_exit, 1'b0);
        ticks(ON_SP - 1);
        chk("R4 second window open", sw_permit, 1'b1);
        one_tick();
        chk("R4 second off entered", sw_permit, 1'b0);
        chk("R4 second enter pulse", off_enter, 1'b1);
    endtask

    task automatic t_uv_stretch();
        en_line = 1'b1; line_uv = 1'b0; sense_present = 1'b1;
        apply_reset();
        ticks(ON_SP);
        chk("R5 off entered", sw_permit, 1'b0);
        ticks(3);
        line_uv = 1'b1;
        ticks(OFF_SP + 4);
        chk("R5 off stretched by uv", sw_permit, 1'b0);
        line_uv = 1'b0;
        ticks(OFF_SP - 4);
        chk("R5 remaining off time", sw_permit, 1'b0);
        one_tick();
        chk("R5 permit after remaining off", sw_permit, 1'b1);
        chk("R5 exit pulse", off_exit, 1'b1);
    endtask

    task automatic t_uv_nosense();
        en_line = 1'b1; line_uv = 1'b1; sense_present = 1'b0;
        apply_reset();
        chk("R6 permit with uv unsensed", sw_permit, 1'b1);
        ticks(ON_SP);
        chk("R6 off entered normally", sw_permit, 1'b0);
        ticks(OFF_SP - 1);
        chk("R6 off not stretched", sw_permit, 1'b0);
        one_tick();
        chk("R6 off ends on time", sw_permit, 1'b1);
        line_uv = 1'b0; sense_present = 1'b1;
    endtask

    task automatic t_powerup();
        en_line = 1'b1; line_uv = 1'b1; sense_present = 1'b1;
        apply_reset();
        chk("R8 permit held at power-up", sw_permit, 1'b0);
        ticks(2 * ON_SP);
        chk("R8 still held", sw_permit, 1'b0);
        chk("R8 no off entry while held", off_enter, 1'b0);
        line_uv = 1'b0;
        @(negedge clk);
        chk("R8 permit on uv clear", sw_permit, 1'b1);
        one_tick();
        chk("R9 launched", sw_permit, 1'b1);
        line_uv = 1'b1;
        ticks(ON_SP - 2);
        chk("R9 uv ignored while running", sw_permit, 1'b1);
        one_tick();
        chk("R8 window counted from launch", sw_permit, 1'b0);
        chk("R8 enter pulse after frozen window", off_enter, 1'b1);
        line_uv = 1'b0;
    endtask

    initial begin
        t_reset();
        t_regulate();
        t_fault();
        t_uv_stretch();
        t_uv_nosense();
        t_powerup();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule